// File: doc/BRIEF.md
# Memory Access Command Decoder

This block sits on top of the byte layer of a single-wire slave interface and turns the byte stream it receives into accesses to a 256-location register memory. Every transaction opens with a two-byte header. The first byte is a function code and the second is the start address. After the header comes an open-ended stream of data bytes. The function code sets the direction of that stream, and the address moves forward by one for every byte.

With the read code, the block takes bytes from memory and offers them to the bit transmitter. The next byte is always fetched while the current one is still being sent, so the transmitter never waits between bytes. With the write code, the block stores each received byte into memory. A bus reset pulse from the line layer marks a completed reset/presence sequence. It aborts whatever transaction is in progress and re-arms the block for a new function code. Before the first such pulse after power-up, the block does nothing.

Top module: `mem_cmd_decoder`

## Requirements
- R1: After `rst_n` is released, the block ignores every received byte until the first `bus_reset_i` pulse: no write, no read mode, and `tx_valid_o` stays low.
- R2: After a bus reset, the byte 69h followed by an address byte A selects read mode. `rd_active_o` goes high in the cycle after the address byte is accepted. `tx_valid_o` goes high one cycle after that, with `tx_byte_o` equal to the memory content at A.
- R3: In read mode, a `tx_req_i` pulse while `tx_valid_o` is high consumes the byte. `mem_addr_o` advances by one, and `tx_valid_o` is low for exactly one cycle. It then returns high with the content of the new address.
- R4: After a bus reset, the byte 6Ch followed by address A selects write mode (`wr_active_o` high). Each later received byte raises `mem_we_o` in the same cycle as `rx_valid_i`, with `mem_wdata_o` equal to that byte. The first such byte goes to address A, and the address then advances by one per byte.
- R5: The address is 8 bits wide and wraps from FFh to 00h in both read and write streams.
- R6: A first byte other than 69h or 6Ch makes the block ignore all bytes and transmit requests until the next bus reset.
- R7: `bus_reset_i` aborts a transaction at any point and returns the block to waiting for a function code. It takes priority over a received byte in the same cycle, which is then neither written nor decoded.
- R8: In read mode, received bytes have no effect: there is no write, the address does not change and the byte on offer does not change.
- R9: A `tx_req_i` pulse while `tx_valid_o` is low has no effect on the address or on the byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | One-cycle pulse: the line saw a reset/presence sequence |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is on `rx_byte_i` |
| rx_byte_i | input | 8 | Received byte |
| tx_req_i | input | 1 | Transmitter takes the offered byte at its first bit slot |
| tx_valid_o | output | 1 | A byte is on offer on `tx_byte_o` |
| tx_byte_o | output | 8 | Byte to transmit |
| rd_active_o | output | 1 | Read stream in progress (master receives) |
| wr_active_o | output | 1 | Write stream in progress (master transmits) |
| mem_addr_o | output | 8 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |

## Verification
Some results appear in the same cycle as their cause. A write enable and its data follow the byte strobe combinationally. The mode flags change one edge after the address byte or the bus reset. A byte on offer appears two edges after the address byte, and again two edges after each consumed byte, because the memory read register sits in the path. The bench drives one input set in each low clock phase and compares every output against its behavioural model a few nanoseconds later, before that edge. It then advances the model across the edge, so every result is checked in the cycle it is due and in every cycle around it.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
   typedef enum logic [2:0] {
      ST_WAIT    = 3'd0,
      ST_CMD     = 3'd1,
      ST_ADDR_RD = 3'd2,
      ST_ADDR_WR = 3'd3,
      ST_READ    = 3'd4,
      ST_WRITE   = 3'd5,
      ST_IGNORE  = 3'd6
   } mcd_state_e;
endpackage

// File: rtl/mcd_fsm.sv
module mcd_fsm
   import mcd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] CMD_READ  = 8'h69,
   parameter logic [DATA_W-1:0] CMD_WRITE = 8'h6C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset_i,
   input  logic              rx_valid_i,
   input  logic [DATA_W-1:0] rx_byte_i,
   output mcd_state_e        state_o,
   output logic              load_o
);
   mcd_state_e state_q, state_d;
   logic       take;

   assign take = rx_valid_i && !bus_reset_i;

   always_comb begin
      state_d = state_q;
      if (bus_reset_i) begin
         state_d = ST_CMD;
      end else if (rx_valid_i) begin
         unique case (state_q)
            ST_CMD: begin
               if (rx_byte_i == CMD_READ)       state_d = ST_ADDR_RD;
               else if (rx_byte_i == CMD_WRITE) state_d = ST_ADDR_WR;
               else                             state_d = ST_IGNORE;
            end
            ST_ADDR_RD: state_d = ST_READ;
            ST_ADDR_WR: state_d = ST_WRITE;
            default:    state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_WAIT;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
   assign load_o  = take && ((state_q == ST_ADDR_RD) || (state_q == ST_ADDR_WR));
endmodule

// File: rtl/mcd_addr_ctr.sv
module mcd_addr_ctr #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_val_i,
   input  logic              inc_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] start;

   generate
      if (ADDR_W == DATA_W) begin : g_full
         assign start = load_val_i;
      end else begin : g_part
         assign start = load_val_i[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (load_i) addr_q <= start;
      else if (inc_i)  addr_q <= addr_q + 1'b1;
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/mcd_rd_stage.sv
module mcd_rd_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic in_read_i,
   input  logic addr_change_i,
   output logic ready_o
);
   logic ready_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= in_read_i && !addr_change_i;
   end

   assign ready_o = ready_q;
endmodule

// File: rtl/mem_cmd_decoder.sv
module mem_cmd_decoder
   import mcd_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] CMD_READ  = 8'h69,
   parameter logic [DATA_W-1:0] CMD_WRITE = 8'h6C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset_i,
   input  logic              rx_valid_i,
   input  logic [DATA_W-1:0] rx_byte_i,
   input  logic              tx_req_i,
   output logic              tx_valid_o,
   output logic [DATA_W-1:0] tx_byte_o,
   output logic              rd_active_o,
   output logic              wr_active_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_we_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i
);
   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("ADDR_W must lie between 1 and DATA_W");
      end
      if (CMD_READ == CMD_WRITE) begin : g_bad_cmds
         $error("read and write codes must differ");
      end
   endgenerate

   mcd_state_e state;
   logic       load, ready, consume, inc, in_read, in_write;

   mcd_fsm #(
      .DATA_W   (DATA_W),
      .CMD_READ (CMD_READ),
      .CMD_WRITE(CMD_WRITE)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_reset_i(bus_reset_i),
      .rx_valid_i (rx_valid_i),
      .rx_byte_i  (rx_byte_i),
      .state_o    (state),
      .load_o     (load)
   );

   assign in_read  = (state == ST_READ);
   assign in_write = (state == ST_WRITE);

   assign mem_we_o    = in_write && rx_valid_i && !bus_reset_i;
   assign mem_wdata_o = rx_byte_i;
   assign consume     = in_read && ready && tx_req_i && !bus_reset_i;
   assign inc         = consume || mem_we_o;

   mcd_addr_ctr #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .load_val_i(rx_byte_i),
      .inc_i     (inc),
      .addr_o    (mem_addr_o)
   );

   mcd_rd_stage u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_read_i    (in_read && !bus_reset_i),
      .addr_change_i(load || inc),
      .ready_o      (ready)
   );

   assign tx_valid_o  = in_read && ready;
   assign tx_byte_o   = mem_rdata_i;
   assign rd_active_o = in_read;
   assign wr_active_o = in_write;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_reset_i,
   input logic              rx_valid_i,
   input logic              tx_req_i,
   input logic              tx_valid_o,
   input logic              rd_active_o,
   input logic              wr_active_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_we_o
);
   p_mode_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_active_o, wr_active_o}));

   p_we_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (wr_active_o && rx_valid_i));

   p_write_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> (mem_addr_o == $past(mem_addr_o) + 1'b1));

   p_offer_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> rd_active_o);

   p_consume_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && tx_req_i && !bus_reset_i) |=>
         (!tx_valid_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

   p_hold_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_req_i && !bus_reset_i) |=> (tx_valid_o && $stable(mem_addr_o)));

   p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_i |=> (!rd_active_o && !wr_active_o && !tx_valid_o));

   p_no_write_on_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_i |-> !mem_we_o);
endmodule

bind mem_cmd_decoder mcd_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_reset_i(bus_reset_i),
   .rx_valid_i (rx_valid_i),
   .tx_req_i   (tx_req_i),
   .tx_valid_o (tx_valid_o),
   .rd_active_o(rd_active_o),
   .wr_active_o(wr_active_o),
   .mem_addr_o (mem_addr_o),
   .mem_we_o   (mem_we_o)
);

// File: tb/mem_cmd_decoder_test.sv
module mem_cmd_decoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_reset_i = 1'b0;
   logic       rx_valid_i = 1'b0;
   logic [7:0] rx_byte_i = 8'h00;
   logic       tx_req_i = 1'b0;
   logic       tx_valid_o, rd_active_o, wr_active_o, mem_we_o;
   logic [7:0] tx_byte_o, mem_addr_o, mem_wdata_o;
   logic [7:0] mem_rdata_i = 8'h00;

   logic [7:0] mem [256];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference: 0 wait,1 cmd,2 addr-rd,3 addr-wr,4 read,5 write,6 ignore
   int m_st = 0;
   int m_addr = 0;
   bit m_ready = 0;

   always #10 clk = ~clk;

   mem_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i),
      .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .tx_req_i(tx_req_i),
      .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
      .rd_active_o(rd_active_o), .wr_active_o(wr_active_o),
      .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
   );

   always @(posedge clk) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      mem_rdata_i <= mem[mem_addr_o];
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input bit br, input bit rv, input logic [7:0] rb,
                       input bit tq, input string tag);
      bit e_we;
      @(negedge clk);
      bus_reset_i = br; rx_valid_i = rv; rx_byte_i = rb; tx_req_i = tq;
      #3;
      e_we = (m_st == 5) && rv && !br;
      chk(tag, "rd_active", int'(rd_active_o), int'(m_st == 4));
      chk(tag, "wr_active", int'(wr_active_o), int'(m_st == 5));
      chk(tag, "mem_addr", int'(mem_addr_o), m_addr);
      chk(tag, "mem_we", int'(mem_we_o), int'(e_we));
      if (e_we) chk(tag, "mem_wdata", int'(mem_wdata_o), int'(rb));
      chk(tag, "tx_valid", int'(tx_valid_o), int'((m_st == 4) && m_ready));
      if ((m_st == 4) && m_ready) chk(tag, "tx_byte", int'(tx_byte_o), int'(mem[m_addr]));
      @(posedge clk);
      #1;
      if (br) begin
         m_st = 1; m_ready = 0;
      end else begin
         case (m_st)
            1: if (rv) m_st = (rb == 8'h69) ? 2 : (rb == 8'h6C) ? 3 : 6;
            2: if (rv) begin m_addr = rb; m_st = 4; m_ready = 0; end
            3: if (rv) begin m_addr = rb; m_st = 5; end
            4: if (tq && m_ready) begin m_addr = (m_addr + 1) % 256; m_ready = 0; end
               else m_ready = 1;
            5: if (rv) m_addr = (m_addr + 1) % 256;
            default: ;
         endcase
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, tag);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
      #45 rst_n = 1'b1;
      // R1: bytes before the first bus reset are ignored
      idle(2, "R1");
      step(0, 1, 8'h69, 0, "R1");
      step(0, 1, 8'hFE, 0, "R1");
      step(0, 0, 8'h00, 1, "R1");
      idle(2, "R1");
      // R2 R3 R5: read from FEh across the wrap
      step(1, 0, 8'h00, 0, "R2");
      step(0, 1, 8'h69, 0, "R2");
      step(0, 1, 8'hFE, 0, "R2");
      idle(2, "R2");
      step(0, 0, 8'h00, 1, "R3");
      step(0, 0, 8'h00, 1, "R9");
      step(0, 0, 8'h00, 0, "R3");
      step(0, 0, 8'h00, 1, "R5");
      idle(1, "R5");
      step(0, 1, 8'h3C, 0, "R8");
      step(0, 1, 8'hC3, 0, "R8");
      step(0, 0, 8'h00, 1, "R3");
      idle(2, "R3");
      // R4 R5: write from FDh across the wrap
      step(1, 0, 8'h00, 0, "R4");
      step(0, 1, 8'h6C, 0, "R4");
      step(0, 1, 8'hFD, 0, "R4");
      step(0, 1, 8'hA1, 0, "R4");
      step(0, 0, 8'h00, 1, "R4");
      step(0, 1, 8'hB2, 0, "R4");
      step(0, 1, 8'hC3, 0, "R5");
      step(0, 1, 8'hD4, 0, "R5");
      // R7: bus reset coincident with a byte drops it
      step(1, 1, 8'hEE, 0, "R7");
      step(0, 1, 8'h69, 0, "R7");
      step(0, 1, 8'hFD, 0, "R4");
      idle(2, "R4");
      for (int i = 0; i < 5; i++) begin
         step(0, 0, 8'h00, 1, "R4");
         idle(1, "R4");
      end
      // R7: abort a read mid-stream, then a write works
      step(1, 0, 8'h00, 0, "R7");
      step(0, 1, 8'h6C, 0, "R7");
      step(0, 1, 8'h10, 0, "R7");
      step(0, 1, 8'h5A, 0, "R7");
      step(1, 0, 8'h00, 0, "R7");
      step(0, 1, 8'h77, 0, "R7");
      // R6: unknown code ignores everything
      step(1, 0, 8'h00, 0, "R6");
      step(0, 1, 8'h55, 0, "R6");
      step(0, 1, 8'h6C, 0, "R6");
      step(0, 1, 8'h00, 0, "R6");
      step(0, 1, 8'hAA, 0, "R6");
      step(0, 1, 8'h69, 0, "R6");
      step(0, 0, 8'h00, 1, "R6");
      idle(2, "R6");
      // read back the stored bytes around the wrap point
      step(1, 0, 8'h00, 0, "R4");
      step(0, 1, 8'h69, 0, "R4");
      step(0, 1, 8'hFF, 0, "R4");
      idle(2, "R4");
      step(0, 0, 8'h00, 1, "R5");
      idle(2, "R5");
      step(0, 0, 8'h00, 1, "R5");
      idle(2, "R5");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule